// File: doc/BRIEF.md
# Four-Channel ADC Scan Controller

This block controls conversions on an external 8-bit converter with four input channels. A conversion run starts on a software start pulse. It can also start on a timer trigger pulse when timer starting is enabled. The block drives a channel number and a one-cycle start pulse to the converter. It then waits for the converter's done strobe, which carries the 8-bit result. Each result goes into the result register of the channel that was converted.

There are two run modes. A single run converts one chosen channel and stops. A scan run converts channels 0, 1, 2 and 3 in that order. With continuous mode set, a scan run starts again at channel 0 after channel 3. An interrupt flag can be set at one of two points: after the first conversion of a sweep, or after the fourth. It is set only when interrupts are enabled. Software clears the flag by pulsing a clear input.

The sequencer has three states:
- `S_IDLE`: waits for a start request.
- `S_LAUNCH`: drives the start pulse for one cycle.
- `S_WAIT`: waits for the done strobe.

It has these transitions:
- `S_IDLE`→`S_LAUNCH` on an accepted request.
- `S_LAUNCH`→`S_WAIT` always.
- `S_WAIT`→`S_LAUNCH` on done when a scan has more channels left, or when a continuous scan wraps around.
- `S_WAIT`→`S_IDLE` on done otherwise.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, `busy`, `irq` and `conv_start` are 0, `conv_chan` is 0, and all result registers hold 0.
- R2: `sw_start` is a start request. `tmr_trig` is a start request only while `cfg_tmr_en` is 1; while `cfg_tmr_en` is 0 it has no effect. `conv_start` is high for exactly one cycle, in the cycle after the request is sampled.
- R3: In single mode (`cfg_scan`=0), the block converts the channel on `cfg_chan`, captured when the request is accepted. It returns to idle after that one conversion.
- R4: In scan mode (`cfg_scan`=1), channels are converted in the order 0, 1, 2, 3. There is one start pulse per channel, and each new start comes in the cycle after the previous done was accepted. The run stops after channel 3.
- R5: In continuous scan (`cfg_cont`=1), after channel 3 the run starts again at channel 0. `cfg_cont` is sampled at each completion of channel 3.
- R6: Channel n's result is held in `res_all[8n+7:8n]`. It takes `conv_data` only when a done strobe is accepted while channel n is being converted. A done strobe while idle changes no result.
- R7: `busy` is 1 from the cycle after a request is accepted until the final done of the run is accepted. Any start request while `busy` is 1 is ignored.
- R8: While `cfg_irq_en` is 0, `irq` is never set.
- R9: With `cfg_irq_last`=0, `irq` is set by the first conversion of each sweep: channel 0 in a scan, or every single-mode conversion. With `cfg_irq_last`=1, `irq` is set by the completion of channel 3 in a scan, and never in single mode.
- R10: `irq` stays set until `irq_clr` is 1. A setting event in the same cycle as `irq_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_start | input | 1 | Software start pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| cfg_tmr_en | input | 1 | Allows the timer trigger to start a run |
| cfg_scan | input | 1 | 1 = scan all channels, 0 = single channel |
| cfg_cont | input | 1 | Continuous scan |
| cfg_chan | input | 2 | Channel for single mode |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_irq_last | input | 1 | 0 = interrupt on first conversion, 1 = on fourth |
| irq_clr | input | 1 | Clears the interrupt flag |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 8 | Converter result, valid with `conv_done` |
| conv_chan | output | 2 | Channel select to the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| busy | output | 1 | A run is in progress |
| irq | output | 1 | Interrupt flag |
| res_all | output | 32 | Four packed 8-bit channel results, channel 0 in the low byte |

## Verification
A table of runs covers single conversions on several channels and full scans. Each run has its own combination of interrupt point and enable. Each run uses its own data base, so a result stored in the wrong register shows up as a mismatched byte. Checking `irq` after every conversion separates a first-point interrupt from a fourth-point one, and either of those from a missing enable.

Directed cases cover the remaining behaviour. They check a timer trigger with timer starting disabled and then enabled. They send a start request while busy and a done strobe while idle. They run a continuous scan that wraps once and then stops when continuous mode is cleared. They also hold clear high through the setting cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LAUNCH = 2'd1,
        S_WAIT   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_scan_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            cfg_scan,
    input  logic            cfg_cont,
    input  logic [CH_W-1:0] cfg_chan,
    input  logic            conv_done,
    output logic            conv_start,
    output logic            busy,
    output logic            done_acc,
    output logic            scan_q,
    output logic [CH_W-1:0] chan_q
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

    seq_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req) state_nx = S_LAUNCH;
            S_LAUNCH: state_nx = S_WAIT;
            S_WAIT:   if (conv_done) begin
                if (scan_q && (chan_q != LAST || cfg_cont)) state_nx = S_LAUNCH;
                else                                        state_nx = S_IDLE;
            end
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        conv_start = (state == S_LAUNCH);
        busy       = (state != S_IDLE);
        done_acc   = (state == S_WAIT) && conv_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            scan_q <= 1'b0;
        end else if (state == S_IDLE && req) begin
            chan_q <= cfg_scan ? '0 : cfg_chan;
            scan_q <= cfg_scan;
        end else if (done_acc && scan_q) begin
            chan_q <= (chan_q == LAST) ? '0 : CH_W'(chan_q + 1'b1);
        end
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R4
    scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && scan_q && chan_q != LAST) |=> (conv_start && chan_q == CH_W'($past(chan_q) + 1'b1)));
    // R7
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_acc) |=> $stable(chan_q));
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NCH  = 4,
    parameter int DW   = 8,
    parameter int CH_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CH_W-1:0]   sel,
    input  logic [DW-1:0]     din,
    output logic [NCH*DW-1:0] res_flat
);
    for (genvar g = 0; g < NCH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                       res_flat[g*DW +: DW] <= '0;
            else if (we && sel == CH_W'(g))   res_flat[g*DW +: DW] <= din;
        end

        // R6
        own_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == CH_W'(g)) |=> $stable(res_flat[g*DW +: DW]));
    end
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_acc,
    input  logic            scan_q,
    input  logic [CH_W-1:0] chan_q,
    input  logic            cfg_irq_en,
    input  logic            cfg_irq_last,
    input  logic            irq_clr,
    output logic            irq
);
    localparam logic [CH_W-1:0] LAST = CH_W'(NCH - 1);

    logic at_first, at_last, set_evt;

    always_comb begin
        at_first = !scan_q || chan_q == '0;
        at_last  = scan_q && chan_q == LAST;
        set_evt  = done_acc && cfg_irq_en && (cfg_irq_last ? at_last : at_first);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (set_evt) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    // R8
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !cfg_irq_en) |=> !irq);
    // R10
    hold_until_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    // R10
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_acc && cfg_irq_en && !cfg_irq_last && !scan_q) |=> irq);
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
    parameter  int NCH  = 4,
    parameter  int DW   = 8,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              tmr_trig,
    input  logic              cfg_tmr_en,
    input  logic              cfg_scan,
    input  logic              cfg_cont,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_irq_en,
    input  logic              cfg_irq_last,
    input  logic              irq_clr,
    input  logic              conv_done,
    input  logic [DW-1:0]     conv_data,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_start,
    output logic              busy,
    output logic              irq,
    output logic [NCH*DW-1:0] res_all
);
    logic            req, done_acc, scan_q;
    logic [CH_W-1:0] chan_q;

    // R2: timer trigger only counts when enabled
    assign req       = sw_start || (tmr_trig && cfg_tmr_en);
    assign conv_chan = chan_q;

    adc_seq_fsm #(.NCH(NCH), .CH_W(CH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_scan(cfg_scan),
        .cfg_cont(cfg_cont), .cfg_chan(cfg_chan), .conv_done(conv_done),
        .conv_start(conv_start), .busy(busy), .done_acc(done_acc),
        .scan_q(scan_q), .chan_q(chan_q)
    );

    adc_result_bank #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_res (
        .clk(clk), .rst_n(rst_n), .we(done_acc), .sel(chan_q),
        .din(conv_data), .res_flat(res_all)
    );

    adc_irq_ctrl #(.NCH(NCH), .CH_W(CH_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .done_acc(done_acc), .scan_q(scan_q),
        .chan_q(chan_q), .cfg_irq_en(cfg_irq_en), .cfg_irq_last(cfg_irq_last),
        .irq_clr(irq_clr), .irq(irq)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !irq && !conv_start && res_all == '0));
endmodule

// File: tb/sim_adc_scan_ctrl.sv
module sim_adc_scan_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sw_start = 0, tmr_trig = 0, cfg_tmr_en = 0, cfg_scan = 0, cfg_cont = 0;
    logic [1:0]  cfg_chan = 0;
    logic        cfg_irq_en = 0, cfg_irq_last = 0, irq_clr = 0, conv_done = 0;
    logic [7:0]  conv_data = 0;
    logic [1:0]  conv_chan;
    logic        conv_start, busy, irq;
    logic [31:0] res_all;

    int checks = 0, errors = 0;
    logic [7:0] er [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_scan_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .tmr_trig(tmr_trig),
        .cfg_tmr_en(cfg_tmr_en), .cfg_scan(cfg_scan), .cfg_cont(cfg_cont),
        .cfg_chan(cfg_chan), .cfg_irq_en(cfg_irq_en), .cfg_irq_last(cfg_irq_last),
        .irq_clr(irq_clr), .conv_done(conv_done), .conv_data(conv_data),
        .conv_chan(conv_chan), .conv_start(conv_start), .busy(busy), .irq(irq),
        .res_all(res_all)
    );

    // fields: [15] scan, [14:13] chan, [12] irq_last, [11] irq_en, [7:0] data base
    localparam logic [15:0] VEC [7] = '{
        {1'b0, 2'd2, 1'b0, 1'b1, 3'd0, 8'h10},
        {1'b0, 2'd1, 1'b1, 1'b1, 3'd0, 8'h21},
        {1'b1, 2'd0, 1'b0, 1'b1, 3'd0, 8'h40},
        {1'b1, 2'd3, 1'b1, 1'b1, 3'd0, 8'h80},
        {1'b1, 2'd0, 1'b1, 1'b0, 3'd0, 8'hC0},
        {1'b0, 2'd3, 1'b0, 1'b0, 3'd0, 8'h5A},
        {1'b0, 2'd0, 1'b0, 1'b1, 3'd0, 8'h33}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_res(input string tag);
        chk(tag, res_all, {er[3], er[2], er[1], er[0]});
    endtask

    task automatic pulse_sw;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    // waits for a start pulse, checks its channel, answers after lat cycles
    task automatic serve(input logic [1:0] ech, input logic [7:0] d, input int lat, input string tag);
        int n = 0;
        while (!conv_start && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " start seen"}, {31'd0, conv_start}, 32'd1);
        chk({tag, " channel"}, {30'd0, conv_chan}, {30'd0, ech});
        repeat (lat) @(negedge clk);
        conv_data = d;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        er[ech] = d;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) er[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 conv_start", {31'd0, conv_start}, 0);
        chk("R1 conv_chan", {30'd0, conv_chan}, 0);
        chk_res("R1 results");

        // table of runs: R3 R4 R6 R9
        for (int v = 0; v < 7; v++) begin
            logic sc, il, ie, eirq;
            int nconv;
            sc = VEC[v][15]; il = VEC[v][12]; ie = VEC[v][11];
            cfg_scan = sc; cfg_chan = VEC[v][14:13];
            cfg_irq_last = il; cfg_irq_en = ie;
            eirq = 1'b0;
            nconv = sc ? 4 : 1;
            pulse_sw();
            for (int k = 0; k < nconv; k++) begin
                logic [1:0] ch;
                ch = sc ? 2'(k) : VEC[v][14:13];
                serve(ch, VEC[v][7:0] + 8'(k), 1 + (k % 2), sc ? "R4 scan" : "R3 single");
                if (ie && ((!il && k == 0) || (il && sc && ch == 2'd3))) eirq = 1'b1;
                chk(ie ? "R9 irq point" : "R8 irq disabled", {31'd0, irq}, {31'd0, eirq});
            end
            chk("R3 R4 idle after run", {31'd0, busy}, 0);
            chk_res("R6 results");
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            chk("R10 irq cleared", {31'd0, irq}, 0);
        end

        // R2 timer trigger disabled
        cfg_scan = 0; cfg_chan = 2'd1; cfg_irq_en = 0; cfg_tmr_en = 0;
        tmr_trig = 1'b1;
        @(negedge clk);
        tmr_trig = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 4; c++) begin
                if (conv_start || busy) seen++;
                @(negedge clk);
            end
            chk("R2 timer ignored when disabled", seen, 0);
        end

        // R2 timer trigger enabled, start exactly the next cycle, one cycle wide
        cfg_tmr_en = 1'b1;
        tmr_trig = 1'b1;
        @(negedge clk);
        tmr_trig = 1'b0;
        chk("R2 start after timer", {31'd0, conv_start}, 1);
        @(negedge clk);
        chk("R2 start one cycle", {31'd0, conv_start}, 0);
        conv_data = 8'h6C; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; er[1] = 8'h6C;
        chk_res("R2 R6 timer result");
        cfg_tmr_en = 1'b0;

        // R7 request while busy ignored
        cfg_chan = 2'd2;
        pulse_sw();
        @(negedge clk);
        chk("R7 busy in wait", {31'd0, busy}, 1);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        conv_data = 8'h9D; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0; er[2] = 8'h9D;
        chk("R7 idle after done", {31'd0, busy}, 0);
        begin
            int seen = 0;
            for (int c = 0; c < 3; c++) begin
                if (conv_start || busy) seen++;
                @(negedge clk);
            end
            chk("R7 no restart from busy request", seen, 0);
        end
        chk_res("R7 result");

        // R6 done while idle ignored
        conv_data = 8'hEE; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        @(negedge clk);
        chk_res("R6 idle done ignored");

        // R5 continuous scan wraps, stops after cfg_cont cleared
        cfg_scan = 1'b1; cfg_cont = 1'b1;
        pulse_sw();
        for (int k = 0; k < 4; k++) serve(2'(k), 8'hA0 + 8'(k), 1, "R5 first sweep");
        for (int k = 0; k < 3; k++) serve(2'(k), 8'hB0 + 8'(k), 2, "R5 wrapped sweep");
        cfg_cont = 1'b0;
        serve(2'd3, 8'hB3, 1, "R5 final channel");
        chk("R5 stopped", {31'd0, busy}, 0);
        @(negedge clk);
        chk("R5 no further start", {31'd0, conv_start}, 0);
        chk_res("R5 results");

        // R10 set wins over simultaneous clear
        cfg_scan = 1'b0; cfg_chan = 2'd0; cfg_irq_en = 1'b1; cfg_irq_last = 1'b0;
        irq_clr = 1'b1;
        pulse_sw();
        serve(2'd0, 8'h4E, 1, "R10 conv");
        chk("R10 set beats clear", {31'd0, irq}, 1);
        @(negedge clk);
        chk("R10 clear afterwards", {31'd0, irq}, 0);
        irq_clr = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule